// File: doc/BRIEF.md
# Four-Channel Two-Phase DMA Engine

This block moves data between memory locations on behalf of four independent channels. Each transfer unit takes two bus phases. A read phase fetches one item from the channel's source address into an internal holding register. A write phase then stores that item at the channel's destination address. A configurable idle gap of one or two clocks always separates the two phases. After each unit the channel's count goes down by one, and both of its addresses advance by the unit width in bytes.

Each channel is loaded through a shared configuration port. The load carries the source and destination addresses, the unit count, the unit width and the run mode. If the settings are illegal, the channel sets an error flag instead of arming. Each channel also has a level-sensitive request line.

A fixed-priority arbiter picks which requesting, armed channel gets the bus next. A channel in stepwise mode gives up the bus after every unit, so a higher-priority request can take over. A channel in burst mode holds the bus from its first unit to its last. The bus side is a single-master interface with a valid/ready handshake.

Top module: `dma2c_engine`

## Requirements
- R1: Each unit first drives a read phase (`bus_write`=0) at the channel source address and captures `bus_rdata`. It then drives a write phase (`bus_write`=1) at the channel destination address with `bus_wdata` equal to the captured read data.
- R2: Between the read handshake and the start of the write phase, `bus_valid` is low for exactly 1 clock when `gap_two`=0 and for exactly 2 clocks when `gap_two`=1.
- R3: When the bus is free, the armed channel with its request high and the lowest index is granted. Channel 0 has the highest priority.
- R4: A channel loaded with `cfg_mode`=1 (burst) keeps the bus for all its units, whatever other requests are pending. Its next read phase follows its write handshake with no idle clock.
- R5: A channel loaded with `cfg_mode`=0 (stepwise) releases the bus for one idle clock after each unit, and arbitration then runs again. A higher-priority request raised during the unit is granted next.
- R6: `bus_size` shows the unit width (0 byte, 1 halfword, 2 word). After each unit, the source and destination addresses each grow by 1, 2 or 4 bytes.
- R7: The count drops by one per unit. In the clock after the final write handshake, `ch_done` pulses for one clock on that channel's bit only, and the channel disarms.
- R8: A load whose source or destination lies in 0x3FFF000 to 0x3FFFFFF sets that channel's `ch_err` bit and leaves the channel disarmed, so its request causes no bus activity.
- R9: A load in burst mode whose source or destination lies in the peripheral window 0xFFFF000 to 0xFFFFFFF is rejected as in R8. The same addresses in stepwise mode are accepted.
- R10: Once `bus_valid` is high, `bus_valid`, `bus_write` and `bus_addr` hold steady until `bus_ready` is seen high.
- R11: A load with a zero count or with `cfg_size`=3 is rejected as in R8. A later legal load to the same channel clears its `ch_err` bit.
- R12: Requests are sampled as levels. An armed channel with its request low does not start. After reset the bus is idle and `ch_done` and `ch_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for one channel |
| cfg_ch | input | 2 | Channel to load |
| cfg_src | input | 28 | Source start address |
| cfg_dst | input | 28 | Destination start address |
| cfg_cnt | input | 16 | Number of units |
| cfg_size | input | 2 | Unit width code |
| cfg_mode | input | 1 | 0 stepwise, 1 burst |
| gap_two | input | 1 | Idle gap select: 0 one clock, 1 two clocks |
| dreq | input | 4 | Per-channel request levels |
| bus_valid | output | 1 | Bus phase active |
| bus_write | output | 1 | 1 for write phase, 0 for read phase |
| bus_addr | output | 28 | Phase address |
| bus_size | output | 2 | Unit width of the phase |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, taken on read handshake |
| bus_ready | input | 1 | Phase completes when high with bus_valid |
| ch_done | output | 4 | One-clock completion pulse per channel |
| ch_err | output | 4 | Rejected-load flag per channel |

## Verification
The bench raises a high-priority request in the middle of a burst run; a design that re-arbitrated there would put the wrong source address on the bus. It raises one during a stepwise run as well; a design that kept its grant would skip the preemption. It measures the idle clocks between the read and write phases under both gap settings, which catches an off-by-one gap counter. It loads addresses in the forbidden range and in the peripheral window under both modes, along with zero counts. A wrong legality check would either start a rejected channel or refuse a valid one. Random configurations and request patterns with random ready stalls exercise address stepping, the done pulses and the hold of the phase signals.

// File: rtl/dma2c_pkg.sv
package dma2c_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } unit_size_e;

    typedef enum logic {
        MD_STEP  = 1'b0,
        MD_BURST = 1'b1
    } run_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_GAP,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        unit_size_e size;
        run_mode_e  mode;
    } chan_ctl_t;

    localparam logic [31:0] HOLE_LO = 32'h03FF_F000;
    localparam logic [31:0] HOLE_HI = 32'h03FF_FFFF;
    localparam logic [31:0] PERI_LO = 32'h0FFF_F000;
    localparam logic [31:0] PERI_HI = 32'h0FFF_FFFF;

    function automatic logic [2:0] unit_bytes(input unit_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic in_hole(input logic [31:0] a);
        return (a >= HOLE_LO) && (a <= HOLE_HI);
    endfunction

    function automatic logic in_peri(input logic [31:0] a);
        return (a >= PERI_LO) && (a <= PERI_HI);
    endfunction

    function automatic logic load_rejected(input logic [31:0] s,
                                           input logic [31:0] d,
                                           input logic        cnt_zero,
                                           input logic [1:0]  size,
                                           input logic        burst);
        logic bad;
        bad = in_hole(s) || in_hole(d) || cnt_zero || (size == 2'd3);
        if (burst && (in_peri(s) || in_peri(d)))
            bad = 1'b1;
        return bad;
    endfunction

endpackage

// File: rtl/dma2c_chan.sv
module dma2c_chan
    import dma2c_pkg::*;
#(
    parameter int AW = 28,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    input  logic [1:0]    ld_size,
    input  logic          ld_mode,
    input  logic          step,
    output logic          en,
    output logic          err,
    output logic          done,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic          last,
    output chan_ctl_t     ctl
);
    logic [CW-1:0] cnt;
    logic          reject;
    logic [AW-1:0] incr;

    always_comb begin
        reject = load_rejected(32'(ld_src), 32'(ld_dst), (ld_cnt == '0),
                               ld_size, ld_mode);
        incr   = AW'(unit_bytes(ctl.size));
        last   = (cnt == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            err  <= 1'b0;
            done <= 1'b0;
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            ctl  <= '{size: SZ_BYTE, mode: MD_STEP};
        end else begin
            done <= 1'b0;
            if (ld) begin
                if (reject) begin
                    en  <= 1'b0;
                    err <= 1'b1;
                end else begin
                    en       <= 1'b1;
                    err      <= 1'b0;
                    src      <= ld_src;
                    dst      <= ld_dst;
                    cnt      <= ld_cnt;
                    ctl.size <= unit_size_e'(ld_size);
                    ctl.mode <= run_mode_e'(ld_mode);
                end
            end else if (step && en) begin
                cnt <= cnt - CW'(1);
                src <= src + incr;
                dst <= dst + incr;
                if (last) begin
                    en   <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dma2c_arb.sv
module dma2c_arb #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] rq,
    output logic           any,
    output logic [IW-1:0]  idx
);
    logic [NCH:0]   taken;
    logic [NCH-1:0] gnt;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_prio
        assign gnt[i]     = rq[i] & ~taken[i];
        assign taken[i+1] = taken[i] | rq[i];
    end

    always_comb begin
        any = taken[NCH];
        idx = '0;
        for (int i = 0; i < NCH; i++)
            if (gnt[i])
                idx = IW'(i);
    end
endmodule

// File: rtl/dma2c_seq.sv
module dma2c_seq
    import dma2c_pkg::*;
#(
    parameter int AW = 28,
    parameter int DW = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gap_two,
    input  logic          gnt_any,
    input  logic [IW-1:0] gnt_idx,
    input  logic [AW-1:0] cur_src,
    input  logic [AW-1:0] cur_dst,
    input  chan_ctl_t     cur_ctl,
    input  logic          cur_last,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic [IW-1:0] cur_idx,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    output logic          step
);
    phase_e        ph;
    logic          gcnt;
    logic [DW-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cur_idx <= '0;
            gcnt    <= 1'b0;
            hold    <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (gnt_any) begin
                        cur_idx <= gnt_idx;
                        ph      <= PH_READ;
                    end
                end
                PH_READ: begin
                    if (bus_ready) begin
                        hold <= bus_rdata;
                        gcnt <= 1'b0;
                        ph   <= PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (gcnt == gap_two)
                        ph <= PH_WRITE;
                    else
                        gcnt <= 1'b1;
                end
                default: begin
                    if (bus_ready) begin
                        if (cur_ctl.mode == MD_BURST && !cur_last)
                            ph <= PH_READ;
                        else
                            ph <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        bus_valid = (ph == PH_READ) || (ph == PH_WRITE);
        bus_write = (ph == PH_WRITE);
        case (ph)
            PH_READ:  bus_addr = cur_src;
            PH_WRITE: bus_addr = cur_dst;
            default:  bus_addr = '0;
        endcase
        bus_size  = cur_ctl.size;
        bus_wdata = hold;
        step      = (ph == PH_WRITE) && bus_ready;
    end
endmodule

// File: rtl/dma2c_engine.sv
module dma2c_engine
    import dma2c_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 28,
    parameter int DW  = 32,
    parameter int CW  = 16,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [IW-1:0]  cfg_ch,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [CW-1:0]  cfg_cnt,
    input  logic [1:0]     cfg_size,
    input  logic           cfg_mode,
    input  logic           gap_two,
    input  logic [NCH-1:0] dreq,
    output logic           bus_valid,
    output logic           bus_write,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ready,
    output logic [NCH-1:0] ch_done,
    output logic [NCH-1:0] ch_err
);
    logic [AW-1:0]  c_src  [NCH];
    logic [AW-1:0]  c_dst  [NCH];
    chan_ctl_t      c_ctl  [NCH];
    logic [NCH-1:0] c_en;
    logic [NCH-1:0] c_last;
    logic [NCH-1:0] rq;
    logic           gnt_any;
    logic [IW-1:0]  gnt_idx;
    logic [IW-1:0]  cur_idx;
    logic           step;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma2c_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ld      (cfg_we && (cfg_ch == IW'(i))),
            .ld_src  (cfg_src),
            .ld_dst  (cfg_dst),
            .ld_cnt  (cfg_cnt),
            .ld_size (cfg_size),
            .ld_mode (cfg_mode),
            .step    (step && (cur_idx == IW'(i))),
            .en      (c_en[i]),
            .err     (ch_err[i]),
            .done    (ch_done[i]),
            .src     (c_src[i]),
            .dst     (c_dst[i]),
            .last    (c_last[i]),
            .ctl     (c_ctl[i])
        );
    end

    assign rq = dreq & c_en;

    dma2c_arb #(.NCH(NCH), .IW(IW)) u_arb (
        .rq  (rq),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    dma2c_seq #(.AW(AW), .DW(DW), .IW(IW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .gap_two   (gap_two),
        .gnt_any   (gnt_any),
        .gnt_idx   (gnt_idx),
        .cur_src   (c_src[cur_idx]),
        .cur_dst   (c_dst[cur_idx]),
        .cur_ctl   (c_ctl[cur_idx]),
        .cur_last  (c_last[cur_idx]),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .cur_idx   (cur_idx),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .step      (step)
    );
endmodule

// File: rtl/dma2c_engine_chk.sv
module dma2c_engine_chk #(
    parameter int NCH = 4,
    parameter int AW  = 28
) (
    input logic           clk,
    input logic           rst,
    input logic           gap_two,
    input logic           cfg_we,
    input logic           bus_valid,
    input logic           bus_write,
    input logic           bus_ready,
    input logic [AW-1:0]  bus_addr,
    input logic [NCH-1:0] ch_done,
    input logic [NCH-1:0] ch_err
);
    logic       armed;
    logic [1:0] idle_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            idle_n <= 2'd0;
        end else if (bus_valid && bus_ready && !bus_write) begin
            armed  <= 1'b1;
            idle_n <= 2'd0;
        end else if (armed && bus_valid) begin
            armed <= 1'b0;
        end else if (armed && idle_n != 2'd3) begin
            idle_n <= idle_n + 2'd1;
        end
    end

    p_hold_phase_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_write) && $stable(bus_addr)));

    p_gap_len_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && bus_valid) |->
            (bus_write && idle_n == (gap_two ? 2'd2 : 2'd1)));

    p_read_idle_after_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && !bus_write) |=> !bus_valid);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_done));

    p_err_from_load_r8: assert property (@(posedge clk) disable iff (rst)
        (|(ch_err & ~$past(ch_err))) |-> $past(cfg_we));
endmodule

bind dma2c_engine dma2c_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gap_two   (gap_two),
    .cfg_we    (cfg_we),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .ch_done   (ch_done),
    .ch_err    (ch_err)
);

// File: tb/dma2c_engine_test.sv
`timescale 1ns/1ps
module dma2c_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [27:0] cfg_src = '0;
    logic [27:0] cfg_dst = '0;
    logic [15:0] cfg_cnt = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_mode = 1'b0;
    logic        gap_two = 1'b0;
    logic [3:0]  dreq = '0;
    logic        bus_valid, bus_write;
    logic [27:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic [3:0]  ch_done, ch_err;

    always #2.5 clk = ~clk;

    dma2c_engine uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
        .cfg_size(cfg_size), .cfg_mode(cfg_mode), .gap_two(gap_two),
        .dreq(dreq), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .ch_done(ch_done), .ch_err(ch_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [27:0] m_src [4];
    logic [27:0] m_dst [4];
    int          m_cnt [4];
    logic [1:0]  m_size [4];
    bit          m_mode [4];
    bit          m_en [4];
    int          lock = -1;
    int          act = 0;
    logic [31:0] exp_data = '0;
    bit          mon_on = 1'b0;
    bit          rand_req = 1'b0;
    logic [3:0]  inject = '0;
    logic [3:0]  pend_done = '0;
    int          post_wr = 0;
    bit          gap_arm = 1'b0;
    int          gap_n = 0;
    int          wleft = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] actual, input logic [63:0] expect_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, actual, expect_v);
        end
    endtask

    function automatic logic [31:0] dfun(input logic [27:0] a);
        return {4'h5, a} ^ 32'h1234_5678;
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit rejected(input logic [27:0] s, input logic [27:0] d,
                                    input int n, input logic [1:0] sz, input bit md);
        bit hole, peri;
        hole = (s >= 28'h3FFF000 && s <= 28'h3FFFFFF) ||
               (d >= 28'h3FFF000 && d <= 28'h3FFFFFF);
        peri = (s >= 28'hFFFF000) || (d >= 28'hFFFF000);
        return hole || (n == 0) || (sz == 2'd3) || (md && peri);
    endfunction

    function automatic logic [3:0] en_mask();
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = m_en[i];
        return m;
    endfunction

    task automatic read_hs();
        int e;
        e = -1;
        if (lock >= 0) e = lock;
        else
            for (int i = 3; i >= 0; i--)
                if (dreq[i] && m_en[i]) e = i;
        if (e < 0) begin
            chk(1'b0, "R12 read with no eligible channel", 64'(bus_addr), 64'h0);
            e = 0;
        end
        chk(bus_addr == m_src[e], "R3/R4 read source of granted channel",
            64'(bus_addr), 64'(m_src[e]));
        chk(bus_size == m_size[e], "R6 read size", 64'(bus_size), 64'(m_size[e]));
        act = e;
        exp_data = dfun(bus_addr);
        gap_arm = 1'b1;
        gap_n = 0;
    endtask

    task automatic write_hs();
        logic [3:0] r;
        chk(bus_addr == m_dst[act], "R1 write destination", 64'(bus_addr), 64'(m_dst[act]));
        chk(bus_wdata == exp_data, "R1 write data equals read data", 64'(bus_wdata), 64'(exp_data));
        chk(bus_size == m_size[act], "R6 write size", 64'(bus_size), 64'(m_size[act]));
        m_cnt[act]--;
        m_src[act] = m_src[act] + 28'(nbytes(m_size[act]));
        m_dst[act] = m_dst[act] + 28'(nbytes(m_size[act]));
        if (m_cnt[act] == 0) begin
            m_en[act] = 1'b0;
            pend_done[act] = 1'b1;
        end
        if (m_mode[act] && m_cnt[act] > 0) begin
            lock = act;
            post_wr = 2;
        end else begin
            lock = -1;
            post_wr = 1;
        end
        if (rand_req) begin
            r = 4'($urandom_range(15, 0));
            if ((r & en_mask()) == 4'h0) r = en_mask();
            dreq = r;
        end
        dreq = dreq | inject;
        inject = '0;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (pend_done != 4'h0 || ch_done != 4'h0)
                chk(ch_done == pend_done, "R7 done pulse", 64'(ch_done), 64'(pend_done));
            pend_done = '0;
            if (post_wr == 1)
                chk(!bus_valid, "R5 bus released after stepwise unit", 64'(bus_valid), 64'h0);
            else if (post_wr == 2)
                chk(bus_valid && !bus_write, "R4 burst continues with no idle clock",
                    64'({bus_valid, bus_write}), 64'h2);
            post_wr = 0;
            if (gap_arm) begin
                if (!bus_valid) gap_n++;
                else begin
                    chk(bus_write && gap_n == (gap_two ? 2 : 1), "R2 idle gap length",
                        64'(gap_n), 64'(gap_two ? 2 : 1));
                    gap_arm = 1'b0;
                end
            end
            if (bus_valid) begin
                if (wleft == 0) bus_ready = 1'b1;
                else begin
                    bus_ready = 1'b0;
                    wleft--;
                end
            end else bus_ready = 1'b0;
            bus_rdata = dfun(bus_addr);
            if (bus_valid && bus_ready) begin
                wleft = $urandom_range(2, 0);
                if (!bus_write) read_hs();
                else write_hs();
            end
        end
    end

    task automatic load(input int ch, input logic [27:0] s, input logic [27:0] d,
                        input int n, input logic [1:0] sz, input bit md, input string tag);
        bit bad;
        bad = rejected(s, d, n, sz, md);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_src = s; cfg_dst = d;
        cfg_cnt = 16'(n); cfg_size = sz; cfg_mode = md;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(ch_err[ch] == bad, tag, 64'(ch_err[ch]), 64'(bad));
        if (!bad) begin
            m_src[ch] = s; m_dst[ch] = d; m_cnt[ch] = n;
            m_size[ch] = sz; m_mode[ch] = md;
        end
        m_en[ch] = !bad;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            if (en_mask() == 4'h0 && !bus_valid && !gap_arm) break;
        end
        repeat (3) @(negedge clk);
        chk(en_mask() == 4'h0, "R7 all channels finished", 64'(en_mask()), 64'h0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_cnt[i] = 0; m_src[i] = '0; m_dst[i] = '0;
            m_size[i] = '0; m_mode[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!bus_valid && ch_done == 4'h0 && ch_err == 4'h0, "R12 reset state",
            64'({bus_valid, ch_done, ch_err}), 64'h0);
        rst = 1'b0;
        mon_on = 1'b1;

        // R12: armed channel with request low stays idle
        load(1, 28'h0001000, 28'h0002000, 2, 2'd2, 1'b0, "R12 legal load");
        repeat (8) begin
            @(negedge clk);
            chk(!bus_valid, "R12 no start without request", 64'(bus_valid), 64'h0);
        end
        dreq = 4'b0010;
        wait_idle();
        dreq = '0;

        // R3: priority among three simultaneous requests
        load(3, 28'h0003000, 28'h0013000, 2, 2'd0, 1'b0, "R3 load ch3");
        load(1, 28'h0001100, 28'h0011100, 2, 2'd1, 1'b0, "R3 load ch1");
        load(2, 28'h0002000, 28'h0012000, 2, 2'd2, 1'b0, "R3 load ch2");
        dreq = 4'b1110;
        wait_idle();
        dreq = '0;

        // R4: burst keeps the bus when a higher request appears
        gap_two = 1'b1;
        load(0, 28'h0000400, 28'h0010400, 1, 2'd2, 1'b0, "R4 load ch0");
        load(2, 28'h0002400, 28'h0012400, 3, 2'd1, 1'b1, "R4 load burst ch2");
        dreq = 4'b0100;
        inject = 4'b0001;
        wait_idle();
        dreq = '0;

        // R5: stepwise yields to a higher request
        gap_two = 1'b0;
        load(3, 28'h0003800, 28'h0013800, 3, 2'd0, 1'b0, "R5 load ch3");
        load(1, 28'h0001800, 28'h0011800, 1, 2'd2, 1'b0, "R5 load ch1");
        dreq = 4'b1000;
        inject = 4'b0010;
        wait_idle();
        dreq = '0;

        // R8, R9, R11: rejected loads
        load(1, 28'h3FFF010, 28'h0001000, 2, 2'd2, 1'b0, "R8 source in forbidden range");
        dreq = 4'b0010;
        repeat (10) begin
            @(negedge clk);
            chk(!bus_valid, "R8 rejected channel stays idle", 64'(bus_valid), 64'h0);
        end
        dreq = '0;
        load(2, 28'h0001000, 28'h3FFFFFF, 1, 2'd0, 1'b0, "R8 destination at range end");
        load(0, 28'hFFFF004, 28'h0001000, 2, 2'd2, 1'b1, "R9 burst with peripheral source");
        load(0, 28'h0002000, 28'h0003000, 0, 2'd2, 1'b0, "R11 zero count rejected");
        load(3, 28'h0002000, 28'h0003000, 1, 2'd3, 1'b0, "R11 size code 3 rejected");
        load(3, 28'h0002000, 28'h0003000, 1, 2'd2, 1'b0, "R11 legal reload clears flag");
        load(0, 28'hFFFF008, 28'h0004000, 2, 2'd2, 1'b0, "R9 stepwise peripheral accepted");
        dreq = 4'b1001;
        wait_idle();
        dreq = '0;

        // Random rounds
        for (int rnd = 0; rnd < 25; rnd++) begin
            gap_two = 1'($urandom_range(1, 0));
            for (int ch = 0; ch < 4; ch++) begin
                logic [27:0] s, d;
                bit md;
                md = 1'($urandom_range(1, 0));
                s = 28'h0010000 + 28'(ch << 12) + 28'($urandom_range(63, 0) << 2);
                d = 28'h0800000 + 28'(ch << 12) + 28'($urandom_range(63, 0) << 2);
                if ($urandom_range(7, 0) == 0) begin
                    s = 28'hFFFF000 + 28'($urandom_range(255, 0) << 2);
                    md = 1'b0;
                end
                load(ch, s, d, $urandom_range(4, 1), 2'($urandom_range(2, 0)), md,
                     "R6 random load accepted");
            end
            rand_req = 1'b1;
            dreq = 4'($urandom_range(15, 1));
            wait_idle();
            rand_req = 1'b0;
            dreq = '0;
        end

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule